// File: doc/BRIEF.md
# Shift, Rotate and Bit-Manipulation Unit

This unit performs the single-step bit-movement operations of an 8-bit processor datapath. It rotates and shifts an operand by one position in either direction. It tests, sets or clears one selected bit. It also moves 4-bit halves between the accumulator and a memory byte in either direction. The surrounding datapath fetches the operand and writes the results back. This unit only computes the new byte, the new accumulator and the new flag byte, and raises a write-enable when the result byte is to be stored.

The arithmetic is combinational. One register stage holds the full output set, so every result appears one clock after its inputs are sampled. The flag byte uses fixed bit positions: sign at bit 7, zero at bit 6, half-carry at bit 4, parity at bit 2 (1 means an even number of ones), subtract at bit 1 and carry at bit 0. Bits 5 and 3 pass through every operation unchanged.

The operation code is 5 bits wide. Each requirement below gives the codes it uses. Codes 17 to 31 are unused.

Top module: `sru_unit`

## Requirements
- R1: Circular rotates, code 0 (left) and code 1 (right), move the bit shifted out into the opposite end of the result and also copy it into carry.
- R2: Rotates through carry, code 2 (left) and code 3 (right), insert the old carry (flags bit 0) into the vacated bit, and the bit shifted out becomes the new carry.
- R3: Code 4 shifts left and inserts 0. Code 6 shifts left and inserts 1. Code 5 shifts right and keeps bit 7. Code 7 shifts right and inserts 0. In all four, the bit shifted out becomes the new carry.
- R4: Codes 0 to 7 set sign from result bit 7, set zero when the result is 0, and set parity when the result has an even number of ones. They clear half-carry and subtract, keep flag bits 5 and 3, and raise the write-enable.
- R5: Codes 8, 9, 10 and 11 are the reduced-flag forms of codes 0, 1, 2 and 3. They give the same result and carry, clear half-carry and subtract, keep sign, zero, parity and bits 5 and 3, and raise the write-enable.
- R6: Bit test, code 12, reads bit `bit_idx_i` of the operand. Zero and parity are both set when that bit is 0. Sign is set only when index 7 is tested and the bit is 1. Half-carry is set and subtract is cleared. Carry and bits 5 and 3 are kept, the result equals the operand, and the write-enable stays low.
- R7: Bit set, code 13, and bit clear, code 14, force only bit `bit_idx_i` of the operand to 1 or 0, leave the whole flag byte unchanged and raise the write-enable.
- R8: Left nibble rotation, code 15, produces a new accumulator made of the old accumulator high nibble and the memory high nibble, and a new memory byte (on `result_o`) made of the memory low nibble (high half) and the old accumulator low nibble (low half).
- R9: Right nibble rotation, code 16, produces a new accumulator made of the old accumulator high nibble and the memory low nibble, and a new memory byte made of the old accumulator low nibble (high half) and the memory high nibble (low half).
- R10: Both nibble rotations set sign, zero and parity from the new accumulator, clear half-carry and subtract, keep carry and bits 5 and 3, and raise the write-enable.
- R11: An unused code (17 to 31) returns the operand as the result, the accumulator and the flag byte unchanged, and keeps the write-enable low.
- R12: All outputs are registered and reflect the inputs sampled at the previous rising clock edge. While reset is active, every output is 0. On every code except 15 and 16, `acc_o` equals `acc_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| operand_i | input | 8 | Operand byte (memory byte for nibble rotation) |
| bit_idx_i | input | 3 | Bit index for test, set and clear |
| acc_i | input | 8 | Accumulator value |
| flags_i | input | 8 | Current flag byte |
| result_o | output | 8 | Result byte |
| acc_o | output | 8 | Updated accumulator |
| flags_o | output | 8 | Updated flag byte |
| wr_en_o | output | 1 | Result byte is to be written back |

## Verification
The assertions check, on every cycle, the properties that hold for each class of operation. They confirm that shifts and rotates clear half-carry and subtract, and that the reduced-flag rotates keep sign, zero and parity. They also confirm that bit set and clear touch one bit and no flags, that bit test never writes, that nibble rotation keeps the accumulator high half, and that unused codes are passive. Exact result values, carry chaining, the parity and sign rules of bit test, and the precise nibble placement are shown only by the bench's sweep. That sweep covers every operation code against every operand value with both carry states, and compares each output against arithmetic written independently of the RTL.

// File: rtl/sru_pkg.sv
package sru_pkg;

    typedef enum logic [4:0] {
        OP_ROL_C  = 5'd0,
        OP_ROR_C  = 5'd1,
        OP_ROL_K  = 5'd2,
        OP_ROR_K  = 5'd3,
        OP_SHL_0  = 5'd4,
        OP_SAR    = 5'd5,
        OP_SHL_1  = 5'd6,
        OP_SHR_0  = 5'd7,
        OP_AROL_C = 5'd8,
        OP_AROR_C = 5'd9,
        OP_AROL_K = 5'd10,
        OP_AROR_K = 5'd11,
        OP_BTEST  = 5'd12,
        OP_BSET   = 5'd13,
        OP_BCLR   = 5'd14,
        OP_NROL   = 5'd15,
        OP_NROR   = 5'd16
    } sru_op_e;

    localparam int FLAG_W = 8;
    localparam int FB_C   = 0;
    localparam int FB_N   = 1;
    localparam int FB_P   = 2;
    localparam int FB_H   = 4;
    localparam int FB_Z   = 6;
    localparam int FB_S   = 7;

endpackage

// File: rtl/sru_shift_core.sv
module sru_shift_core
    import sru_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  sru_op_e            op_i,
    input  logic [DATA_W-1:0]  value_i,
    input  logic               carry_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               carry_o
);
    logic go_left;
    logic fill_bit;

    always_comb begin
        go_left  = 1'b0;
        fill_bit = 1'b0;
        unique case (op_i)
            OP_ROL_C, OP_AROL_C: begin go_left = 1'b1; fill_bit = value_i[DATA_W-1]; end
            OP_ROR_C, OP_AROR_C: begin go_left = 1'b0; fill_bit = value_i[0]; end
            OP_ROL_K, OP_AROL_K: begin go_left = 1'b1; fill_bit = carry_i; end
            OP_ROR_K, OP_AROR_K: begin go_left = 1'b0; fill_bit = carry_i; end
            OP_SHL_0:            begin go_left = 1'b1; fill_bit = 1'b0; end
            OP_SHL_1:            begin go_left = 1'b1; fill_bit = 1'b1; end
            OP_SAR:              begin go_left = 1'b0; fill_bit = value_i[DATA_W-1]; end
            OP_SHR_0:            begin go_left = 1'b0; fill_bit = 1'b0; end
            default:             begin go_left = 1'b0; fill_bit = 1'b0; end
        endcase
    end

    always_comb begin
        if (go_left) begin
            result_o = {value_i[DATA_W-2:0], fill_bit};
            carry_o  = value_i[DATA_W-1];
        end else begin
            result_o = {fill_bit, value_i[DATA_W-1:1]};
            carry_o  = value_i[0];
        end
    end

endmodule

// File: rtl/sru_bit_core.sv
module sru_bit_core #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              force_one_i,
    output logic [DATA_W-1:0] forced_o,
    output logic              tested_o,
    output logic              top_hit_o
);
    logic [DATA_W-1:0] sel_mask;

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign sel_mask[g] = (idx_i == IDX_W'(g));
    end

    assign tested_o  = |(value_i & sel_mask);
    assign top_hit_o = sel_mask[DATA_W-1] & tested_o;
    assign forced_o  = force_one_i ? (value_i | sel_mask) : (value_i & ~sel_mask);

endmodule

// File: rtl/sru_nibble_core.sv
module sru_nibble_core #(
    parameter int DATA_W = 8,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              to_left_i,
    input  logic [DATA_W-1:0] mem_i,
    input  logic [DATA_W-1:0] acc_i,
    output logic [DATA_W-1:0] mem_o,
    output logic [DATA_W-1:0] acc_o
);
    logic [HALF_W-1:0] a_hi, a_lo, m_hi, m_lo;

    assign a_hi = acc_i[DATA_W-1:HALF_W];
    assign a_lo = acc_i[HALF_W-1:0];
    assign m_hi = mem_i[DATA_W-1:HALF_W];
    assign m_lo = mem_i[HALF_W-1:0];

    always_comb begin
        if (to_left_i) begin
            acc_o = {a_hi, m_hi};
            mem_o = {m_lo, a_lo};
        end else begin
            acc_o = {a_hi, m_lo};
            mem_o = {a_lo, m_hi};
        end
    end

endmodule

// File: rtl/sru_unit.sv
module sru_unit
    import sru_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0] result_o,
    output logic [DATA_W-1:0] acc_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              wr_en_o
);
    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic [DATA_W-1:0] acc;
        logic [FLAG_W-1:0] flags;
        logic              we;
    } sru_out_t;

    sru_op_e           op;
    logic [DATA_W-1:0] sh_res;
    logic              sh_cy;
    logic [DATA_W-1:0] bit_res;
    logic              bit_val;
    logic              bit_top;
    logic [DATA_W-1:0] nb_mem;
    logic [DATA_W-1:0] nb_acc;
    sru_out_t          out_d, out_q;

    assign op = sru_op_e'(op_i);

    sru_shift_core #(.DATA_W(DATA_W)) shift_i (
        .op_i     (op),
        .value_i  (operand_i),
        .carry_i  (flags_i[FB_C]),
        .result_o (sh_res),
        .carry_o  (sh_cy)
    );

    sru_bit_core #(.DATA_W(DATA_W)) bit_i (
        .value_i     (operand_i),
        .idx_i       (bit_idx_i),
        .force_one_i (op == OP_BSET),
        .forced_o    (bit_res),
        .tested_o    (bit_val),
        .top_hit_o   (bit_top)
    );

    sru_nibble_core #(.DATA_W(DATA_W)) nib_i (
        .to_left_i (op == OP_NROL),
        .mem_i     (operand_i),
        .acc_i     (acc_i),
        .mem_o     (nb_mem),
        .acc_o     (nb_acc)
    );

    always_comb begin
        out_d.result = operand_i;
        out_d.acc    = acc_i;
        out_d.flags  = flags_i;
        out_d.we     = 1'b0;
        case (op)
            OP_ROL_C, OP_ROR_C, OP_ROL_K, OP_ROR_K,
            OP_SHL_0, OP_SAR, OP_SHL_1, OP_SHR_0: begin
                out_d.result      = sh_res;
                out_d.flags[FB_S] = sh_res[DATA_W-1];
                out_d.flags[FB_Z] = (sh_res == '0);
                out_d.flags[FB_P] = ~^sh_res;
                out_d.flags[FB_H] = 1'b0;
                out_d.flags[FB_N] = 1'b0;
                out_d.flags[FB_C] = sh_cy;
                out_d.we          = 1'b1;
            end
            OP_AROL_C, OP_AROR_C, OP_AROL_K, OP_AROR_K: begin
                out_d.result      = sh_res;
                out_d.flags[FB_H] = 1'b0;
                out_d.flags[FB_N] = 1'b0;
                out_d.flags[FB_C] = sh_cy;
                out_d.we          = 1'b1;
            end
            OP_BTEST: begin
                out_d.flags[FB_Z] = ~bit_val;
                out_d.flags[FB_P] = ~bit_val;
                out_d.flags[FB_S] = bit_top;
                out_d.flags[FB_H] = 1'b1;
                out_d.flags[FB_N] = 1'b0;
            end
            OP_BSET, OP_BCLR: begin
                out_d.result = bit_res;
                out_d.we     = 1'b1;
            end
            OP_NROL, OP_NROR: begin
                out_d.result      = nb_mem;
                out_d.acc         = nb_acc;
                out_d.flags[FB_S] = nb_acc[DATA_W-1];
                out_d.flags[FB_Z] = (nb_acc == '0);
                out_d.flags[FB_P] = ~^nb_acc;
                out_d.flags[FB_H] = 1'b0;
                out_d.flags[FB_N] = 1'b0;
                out_d.we          = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.result;
    assign acc_o    = out_q.acc;
    assign flags_o  = out_q.flags;
    assign wr_en_o  = out_q.we;

endmodule

// File: rtl/sru_unit_chk.sv
module sru_unit_chk
    import sru_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W  = $clog2(DATA_W),
    localparam int HALF_W = DATA_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        op_i,
    input logic [DATA_W-1:0] operand_i,
    input logic [IDX_W-1:0]  bit_idx_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [DATA_W-1:0] result_o,
    input logic [DATA_W-1:0] acc_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic              wr_en_o
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_shift_hn_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) <= 5'd11) |-> (!flags_o[FB_H] && !flags_o[FB_N] && wr_en_o));

    p_acc_rot_keep_szp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) >= 5'd8 && $past(op_i) <= 5'd11) |->
        (flags_o[FB_S] == $past(flags_i[FB_S]) && flags_o[FB_Z] == $past(flags_i[FB_Z])
         && flags_o[FB_P] == $past(flags_i[FB_P])));

    p_btest_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 5'd12) |->
        (!wr_en_o && flags_o[FB_H] && !flags_o[FB_N] && flags_o[FB_C] == $past(flags_i[FB_C])));

    p_bset_single_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 5'd13) |->
        (result_o[$past(bit_idx_i)] && $countones(result_o ^ $past(operand_i)) <= 1
         && flags_o == $past(flags_i)));

    p_bclr_single_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == 5'd14) |->
        (!result_o[$past(bit_idx_i)] && $countones(result_o ^ $past(operand_i)) <= 1
         && flags_o == $past(flags_i)));

    p_nibble_keep_hi_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(op_i) == 5'd15 || $past(op_i) == 5'd16)) |->
        (acc_o[DATA_W-1:HALF_W] == $past(acc_i[DATA_W-1:HALF_W]) && !flags_o[FB_H] && !flags_o[FB_N]));

    p_unused_passive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) > 5'd16) |->
        (!wr_en_o && result_o == $past(operand_i) && flags_o == $past(flags_i)
         && acc_o == $past(acc_i)));

    p_acc_untouched_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) != 5'd15 && $past(op_i) != 5'd16) |-> (acc_o == $past(acc_i)));

endmodule

bind sru_unit sru_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .operand_i (operand_i),
    .bit_idx_i (bit_idx_i),
    .acc_i     (acc_i),
    .flags_i   (flags_i),
    .result_o  (result_o),
    .acc_o     (acc_o),
    .flags_o   (flags_o),
    .wr_en_o   (wr_en_o)
);

// File: tb/sru_unit_tb_top.sv
module sru_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] op;
    logic [7:0] operand;
    logic [2:0] idx;
    logic [7:0] acc;
    logic [7:0] flags;
    logic [7:0] result_o;
    logic [7:0] acc_o;
    logic [7:0] flags_o;
    logic       wr_en_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sru_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .operand_i (operand),
        .bit_idx_i (idx),
        .acc_i     (acc),
        .flags_i   (flags),
        .result_o  (result_o),
        .acc_o     (acc_o),
        .flags_o   (flags_o),
        .wr_en_o   (wr_en_o)
    );

    function automatic string req_of(int code);
        case (code)
            0, 1:           return "R1";
            2, 3:           return "R2";
            4, 5, 6, 7:     return "R3";
            8, 9, 10, 11:   return "R5";
            12:             return "R6";
            13, 14:         return "R7";
            15:             return "R8";
            16:             return "R9";
            default:        return "R11";
        endcase
    endfunction

    function automatic logic [7:0] szp(logic [7:0] r);
        int ones = 0;
        for (int b = 0; b < 8; b++) ones += int'(r[b]);
        return (r >= 8'd128 ? 8'h80 : 8'h00) | (r == 8'd0 ? 8'h40 : 8'h00)
             | ((ones % 2) == 0 ? 8'h04 : 8'h00);
    endfunction

    // returns {we, acc, flags, result}
    function automatic logic [24:0] model(int code, logic [7:0] v, logic [2:0] ix,
                                          logic [7:0] a, logic [7:0] f);
        int   vi = int'(v);
        int   ci = int'(f[0]);
        int   ri = vi;
        int   co = 0;
        logic [7:0] r;
        logic [7:0] na = a;
        logic [7:0] nf = f;
        logic       we = 1'b0;
        int   base = (code >= 8 && code <= 11) ? code - 8 : code;
        if (code <= 11) begin
            case (base)
                0: begin ri = (vi * 2) % 256 + vi / 128;   co = vi / 128; end
                1: begin ri = vi / 2 + (vi % 2) * 128;     co = vi % 2;   end
                2: begin ri = (vi * 2) % 256 + ci;         co = vi / 128; end
                3: begin ri = vi / 2 + ci * 128;           co = vi % 2;   end
                4: begin ri = (vi * 2) % 256;              co = vi / 128; end
                5: begin ri = vi / 2 + (vi / 128) * 128;   co = vi % 2;   end
                6: begin ri = (vi * 2) % 256 + 1;          co = vi / 128; end
                default: begin ri = vi / 2;                co = vi % 2;   end
            endcase
            r  = 8'(ri);
            we = 1'b1;
            if (code <= 7) nf = (f & 8'h28) | szp(r) | 8'(co);
            else           nf = (f & 8'hEC) | 8'(co);
        end else if (code == 12) begin
            r  = v;
            nf = (f & 8'h29) | 8'h10 | (v[ix] ? 8'h00 : 8'h44)
               | ((ix == 3'd7 && v[ix]) ? 8'h80 : 8'h00);
        end else if (code == 13) begin
            r  = v | 8'(1 << ix);
            we = 1'b1;
        end else if (code == 14) begin
            r  = v & ~8'(1 << ix);
            we = 1'b1;
        end else if (code == 15) begin
            na = (a & 8'hF0) | (v >> 4);
            r  = 8'((int'(v) * 16) % 256) | (a & 8'h0F);
            nf = (f & 8'h29) | szp(na);
            we = 1'b1;
        end else if (code == 16) begin
            na = (a & 8'hF0) | (v & 8'h0F);
            r  = 8'(int'(a & 8'h0F) * 16) | (v >> 4);
            nf = (f & 8'h29) | szp(na);
            we = 1'b1;
        end else begin
            r = v;
        end
        return {we, na, nf, r};
    endfunction

    task automatic check_vec(string req, logic [24:0] exp);
        logic [24:0] got = {wr_en_o, acc_o, flags_o, result_o};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s op=%0d v=%02h idx=%0d acc=%02h flg=%02h: got we=%b acc=%02h flg=%02h res=%02h, exp we=%b acc=%02h flg=%02h res=%02h",
                     req, op, operand, idx, acc, flags,
                     got[24], got[23:16], got[15:8], got[7:0],
                     exp[24], exp[23:16], exp[15:8], exp[7:0]);
        end
    endtask

    initial begin
        rst_n   = 1'b0;
        op      = 5'd0;
        operand = 8'hA5;
        idx     = 3'd0;
        acc     = 8'h3C;
        flags   = 8'hFF;
        repeat (3) @(negedge clk);
        // R12: reset holds all outputs at zero
        check_vec("R12", 25'd0);
        rst_n = 1'b1;
        for (int code = 0; code < 32; code++) begin
            for (int c = 0; c < 2; c++) begin
                for (int v = 0; v < 256; v++) begin
                    logic [24:0] exp;
                    op      = 5'(code);
                    operand = 8'(v);
                    idx     = 3'((v + 3 * c + code + v / 8) % 8);
                    acc     = 8'(v * 29 + 17 * c + code * 5);
                    flags   = {7'(v * 13 + code * 7 + c * 41), 1'(c)};
                    exp     = model(code, operand, idx, acc, flags);
                    @(negedge clk);
                    // one register stage: sampled one edge after drive (R12)
                    check_vec(req_of(code), exp);
                end
            end
        end
        // R4: explicit zero result sets zero and even parity
        op = 5'd7; operand = 8'h01; idx = 3'd0; acc = 8'h00; flags = 8'h00;
        @(negedge clk);
        check_vec("R4", {1'b1, 8'h00, 8'h45, 8'h00});
        // R6: testing bit 7 when set gives sign
        op = 5'd12; operand = 8'h80; idx = 3'd7; acc = 8'h11; flags = 8'h01;
        @(negedge clk);
        check_vec("R6", {1'b0, 8'h11, 8'h91, 8'h80});
        // R10: nibble rotation giving zero accumulator
        op = 5'd15; operand = 8'h0B; idx = 3'd0; acc = 8'h00; flags = 8'h13;
        @(negedge clk);
        check_vec("R10", {1'b1, 8'h00, 8'h45, 8'hB0});
        // R12: re-entering reset clears outputs
        rst_n = 1'b0;
        #1;
        check_vec("R12", 25'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule